// File: doc/BRIEF.md
# PCI Bus Access Latency Monitor

This block watches one PCI agent from the side and drives nothing on the bus. It samples that agent's request and grant lines together with the shared FRAME#, IRDY# and TRDY# lines. For each access it splits the total latency into three intervals and times each one in clock cycles. The first runs from request to grant. The second runs from the point where the agent may take the bus to its assertion of FRAME#. The third runs from FRAME# to the first target ready. The intervals follow each other, and each one is timed by a single shared saturating counter.

Each interval result appears on its own output with a one-cycle valid strobe. The last result stays on the output until the next one replaces it. For each interval the block also keeps the largest value seen so far, and a synchronous clear input sets these maxima back to zero. A system integrator uses these figures to size data buffers against the worst delays observed in a real system.

Top module: `pci_lat_mon`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every latency, valid and maximum output is zero.
- R2: All bus inputs are active low and are sampled on the rising edge of `clk`. The arbitration value equals the number of edges from the edge where `req_n` is first sampled low to the edge where `gnt_n` is first sampled low, so it is at least 1. It is reported once per request.
- R3: The acquisition interval starts at the edge where `gnt_n` is low while `frame_n` and `irdy_n` are both high. Its value is the number of edges from that edge to the first edge that samples `frame_n` low.
- R4: The target value is the number of edges from the edge that ended the acquisition interval to the first edge that samples `trdy_n` low.
- R5: Each result is registered at its completing edge, together with a valid that is high for exactly one cycle. At most one of the three valids is high in any cycle, and each latency output holds its last value between results.
- R6: If `gnt_n` is sampled high during the acquisition interval before `frame_n` goes low, no acquisition result is produced. The block then waits for a grant on an idle bus and restarts that interval from zero.
- R7: A grant that arrives while `frame_n` or `irdy_n` is low still completes the arbitration interval. The acquisition interval does not start until a grant is sampled on an idle bus.
- R8: If `frame_n` and `irdy_n` are both sampled high during the target interval with no `trdy_n` low, no target result is produced and the block returns to waiting for a request.
- R9: If `req_n` and `gnt_n` are both sampled high before any grant, the request is dropped and no arbitration result is produced.
- R10: The counter and every result saturate at 2^CNT_W-1 (65535 by default) and do not wrap.
- R11: Each maximum output takes a new result only when that result is larger. Otherwise it keeps its value and never decreases while `clr_max` is low.
- R12: When `clr_max` is high at an edge, all three maxima read zero after that edge, even if a result completes at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_max | input | 1 | Synchronous clear of the three maxima |
| req_n | input | 1 | Monitored agent's request, active low |
| gnt_n | input | 1 | Monitored agent's grant, active low |
| frame_n | input | 1 | Shared FRAME#, active low |
| irdy_n | input | 1 | Shared IRDY#, active low |
| trdy_n | input | 1 | Shared TRDY#, active low |
| arb_lat | output | CNT_W | Last request-to-grant count |
| arb_vld | output | 1 | One-cycle strobe for arb_lat |
| acq_lat | output | CNT_W | Last grant-to-FRAME# count |
| acq_vld | output | 1 | One-cycle strobe for acq_lat |
| tgt_lat | output | CNT_W | Last FRAME#-to-TRDY# count |
| tgt_vld | output | 1 | One-cycle strobe for tgt_lat |
| arb_max | output | CNT_W | Largest arbitration count since clear |
| acq_max | output | CNT_W | Largest acquisition count since clear |
| tgt_max | output | CNT_W | Largest target count since clear |

## Verification
The bench grants the agent while another master still holds the bus. A design that starts the acquisition interval at the grant instead of at the idle bus reports a value that is too large.

It withdraws the grant in the middle of the acquisition interval and later grants again. A design that does not abandon the interval either produces two acquisition results or keeps counting from the earlier start.

It also covers three further cases:
- a master abort with no target ready, where a design with a faulty exit hangs or reports a bogus target value;
- a withdrawn request;
- a clear that lands on the same edge as a completing result, where a design that lets the update win leaves a nonzero maximum.

A 70000-cycle arbitration wait shows whether the counter wraps around to a small value or saturates.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_HOLD,
    ST_ACQ,
    ST_TGT
  } lat_state_e;

  localparam int NUM_IV = 3;
  localparam int IV_ARB = 0;
  localparam int IV_ACQ = 1;
  localparam int IV_TGT = 2;
endpackage

// File: rtl/lat_sat_cnt.sv
module lat_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                    val <= '0;
    else if (load)              val <= ONE;
    else if (inc && val != TOP) val <= val + ONE;
  end
endmodule

// File: rtl/lat_seq.sv
module lat_seq
  import lat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_n,
  input  logic              gnt_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  output logic              cnt_load,
  output logic              cnt_inc,
  output logic [NUM_IV-1:0] emit
);
  lat_state_e st, st_nxt;
  logic bus_idle;

  assign bus_idle = frame_n & irdy_n;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  always_comb begin
    st_nxt   = st;
    cnt_load = 1'b0;
    cnt_inc  = 1'b0;
    emit     = '0;
    unique case (st)
      ST_IDLE: if (!req_n) begin
        st_nxt   = ST_ARB;
        cnt_load = 1'b1;
      end
      ST_ARB: begin
        if (!gnt_n) begin
          emit[IV_ARB] = 1'b1;
          if (bus_idle) begin
            st_nxt   = ST_ACQ;
            cnt_load = 1'b1;
          end else begin
            st_nxt = ST_HOLD;
          end
        end else if (req_n) begin
          st_nxt = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!gnt_n && bus_idle) begin
          st_nxt   = ST_ACQ;
          cnt_load = 1'b1;
        end else if (gnt_n && req_n) begin
          st_nxt = ST_IDLE;
        end
      end
      ST_ACQ: begin
        if (!frame_n) begin
          emit[IV_ACQ] = 1'b1;
          st_nxt       = ST_TGT;
          cnt_load     = 1'b1;
        end else if (gnt_n) begin
          st_nxt = ST_HOLD;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_TGT: begin
        if (!trdy_n) begin
          emit[IV_TGT] = 1'b1;
          st_nxt       = ST_IDLE;
        end else if (bus_idle) begin
          st_nxt = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lat_iv_track.sv
module lat_iv_track #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic [W-1:0] lat,
  output logic         vld,
  output logic [W-1:0] peak
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat  <= '0;
      vld  <= 1'b0;
      peak <= '0;
    end else begin
      vld <= upd;
      if (upd) lat <= val;
      if (clr)                    peak <= '0;
      else if (upd && val > peak) peak <= val;
    end
  end
endmodule

// File: rtl/pci_lat_mon.sv
module pci_lat_mon
  import lat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_max,
  input  logic             req_n,
  input  logic             gnt_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  output logic [CNT_W-1:0] arb_lat,
  output logic             arb_vld,
  output logic [CNT_W-1:0] acq_lat,
  output logic             acq_vld,
  output logic [CNT_W-1:0] tgt_lat,
  output logic             tgt_vld,
  output logic [CNT_W-1:0] arb_max,
  output logic             [CNT_W-1:0] acq_max,
  output logic [CNT_W-1:0] tgt_max
);
  logic              cnt_load, cnt_inc;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_IV-1:0] emit;
  logic [CNT_W-1:0]  lat_a  [NUM_IV];
  logic [CNT_W-1:0]  peak_a [NUM_IV];
  logic [NUM_IV-1:0] vld_a;

  lat_seq u_seq (
    .clk(clk), .rst(rst), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .cnt_load(cnt_load), .cnt_inc(cnt_inc), .emit(emit)
  );

  lat_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .inc(cnt_inc), .val(cnt)
  );

  for (genvar i = 0; i < NUM_IV; i++) begin : g_iv
    lat_iv_track #(.W(CNT_W)) u_trk (
      .clk(clk), .rst(rst), .clr(clr_max), .upd(emit[i]), .val(cnt),
      .lat(lat_a[i]), .vld(vld_a[i]), .peak(peak_a[i])
    );
  end

  assign arb_lat = lat_a[IV_ARB];
  assign acq_lat = lat_a[IV_ACQ];
  assign tgt_lat = lat_a[IV_TGT];
  assign arb_vld = vld_a[IV_ARB];
  assign acq_vld = vld_a[IV_ACQ];
  assign tgt_vld = vld_a[IV_TGT];
  assign arb_max = peak_a[IV_ARB];
  assign acq_max = peak_a[IV_ACQ];
  assign tgt_max = peak_a[IV_TGT];
endmodule

// File: rtl/lat_mon_chk.sv
module lat_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_max,
  input logic [CNT_W-1:0] arb_lat,
  input logic             arb_vld,
  input logic [CNT_W-1:0] acq_lat,
  input logic             acq_vld,
  input logic [CNT_W-1:0] tgt_lat,
  input logic             tgt_vld,
  input logic [CNT_W-1:0] arb_max,
  input logic [CNT_W-1:0] acq_max,
  input logic [CNT_W-1:0] tgt_max
);
  // R5
  one_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arb_vld, acq_vld, tgt_vld}));

  // R5
  arb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    arb_vld |=> !arb_vld);

  // R5
  tgt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_vld |=> !tgt_vld);

  // R2
  arb_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    arb_vld |-> arb_lat != '0);

  // R11
  acq_peak_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_vld && !$past(clr_max)) |-> acq_max >= acq_lat);

  // R11
  tgt_peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_max |=> tgt_max >= $past(tgt_max));

  // R12
  clear_max_chk: assert property (@(posedge clk) disable iff (rst)
    clr_max |=> (arb_max == '0 && acq_max == '0 && tgt_max == '0));
endmodule

bind pci_lat_mon lat_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr_max(clr_max),
  .arb_lat(arb_lat), .arb_vld(arb_vld),
  .acq_lat(acq_lat), .acq_vld(acq_vld),
  .tgt_lat(tgt_lat), .tgt_vld(tgt_vld),
  .arb_max(arb_max), .acq_max(acq_max), .tgt_max(tgt_max)
);

// File: tb/tb_pci_lat_mon.sv
module tb_pci_lat_mon;
  localparam int CLK_PER = 10;
  localparam int W       = 16;
  localparam int WD_CYC  = 190000;
  localparam int NVEC    = 6;
  // each row: arbitration, acquisition, target gaps (expected results equal the gaps)
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 1}, '{4, 2, 3}, '{2, 6, 1}, '{7, 1, 9}, '{3, 3, 2}, '{1, 5, 4}
  };

  logic clk = 0, rst = 1, clr_max = 0;
  logic req_n = 1, gnt_n = 1, frame_n = 1, irdy_n = 1, trdy_n = 1;
  logic [W-1:0] arb_lat, acq_lat, tgt_lat, arb_max, acq_max, tgt_max;
  logic arb_vld, acq_vld, tgt_vld;

  int errors = 0, checks = 0;
  int n_arb = 0, n_acq = 0, n_tgt = 0;
  int last_arb = 0, last_acq = 0, last_tgt = 0;

  always #(CLK_PER/2) clk = ~clk;

  pci_lat_mon #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .clr_max(clr_max), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .arb_lat(arb_lat), .arb_vld(arb_vld), .acq_lat(acq_lat), .acq_vld(acq_vld),
    .tgt_lat(tgt_lat), .tgt_vld(tgt_vld),
    .arb_max(arb_max), .acq_max(acq_max), .tgt_max(tgt_max)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (arb_vld) begin n_arb++; last_arb = int'(arb_lat); end
      if (acq_vld) begin n_acq++; last_acq = int'(acq_lat); end
      if (tgt_vld) begin n_tgt++; last_tgt = int'(tgt_lat); end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic release_bus();
    req_n = 1; gnt_n = 1; frame_n = 1; irdy_n = 1; trdy_n = 1;
  endtask

  task automatic access(input int a, input int g, input int t);
    @(negedge clk) req_n = 0;
    repeat (a) @(negedge clk);
    gnt_n = 0;
    repeat (g) @(negedge clk);
    frame_n = 0; irdy_n = 0;
    repeat (t) @(negedge clk);
    trdy_n = 0;
    @(negedge clk) release_bus();
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b_arb, b_acq, b_tgt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 arb_lat", int'(arb_lat), 0);
    chk("R1 max sum", int'(arb_max) + int'(acq_max) + int'(tgt_max), 0);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk("R1 valids after release", int'({arb_vld, acq_vld, tgt_vld}), 0);

    // R2 R3 R4 R5: table of accesses
    for (int i = 0; i < NVEC; i++) begin
      b_arb = n_arb; b_acq = n_acq; b_tgt = n_tgt;
      access(VEC[i][0], VEC[i][1], VEC[i][2]);
      chk("R2 arbitration", last_arb, VEC[i][0]);
      chk("R3 acquisition", last_acq, VEC[i][1]);
      chk("R4 target", last_tgt, VEC[i][2]);
      chk("R5 one pulse each", (n_arb - b_arb) + (n_acq - b_acq) + (n_tgt - b_tgt), 3);
      chk("R5 held value", int'(tgt_lat), VEC[i][2]);
    end
    // R11: maxima of the table
    chk("R11 arb_max", int'(arb_max), 7);
    chk("R11 acq_max", int'(acq_max), 6);
    chk("R11 tgt_max", int'(tgt_max), 9);

    // R7: grant while another master holds the bus
    b_acq = n_acq;
    @(negedge clk) begin req_n = 0; frame_n = 0; irdy_n = 0; end
    repeat (2) @(negedge clk);
    gnt_n = 0;
    repeat (3) @(negedge clk);
    frame_n = 1; irdy_n = 1;
    repeat (2) @(negedge clk);
    frame_n = 0; irdy_n = 0;
    @(negedge clk) trdy_n = 0;
    @(negedge clk) release_bus();
    @(negedge clk);
    chk("R7 arbitration on busy bus", last_arb, 2);
    chk("R7 acquisition from idle", last_acq, 2);
    chk("R7 one acquisition", n_acq - b_acq, 1);

    // R6: grant removed before FRAME#
    b_acq = n_acq;
    @(negedge clk) req_n = 0;
    repeat (2) @(negedge clk);
    gnt_n = 0;
    repeat (2) @(negedge clk);
    gnt_n = 1;
    repeat (3) @(negedge clk);
    chk("R6 no acquisition on abandon", n_acq - b_acq, 0);
    gnt_n = 0;
    repeat (4) @(negedge clk);
    frame_n = 0; irdy_n = 0;
    @(negedge clk) trdy_n = 0;
    @(negedge clk) release_bus();
    @(negedge clk);
    chk("R6 restarted acquisition", last_acq, 4);
    chk("R6 single acquisition", n_acq - b_acq, 1);

    // R8: master abort, no target ready
    b_tgt = n_tgt;
    @(negedge clk) req_n = 0;
    @(negedge clk) gnt_n = 0;
    @(negedge clk) begin frame_n = 0; irdy_n = 0; end
    repeat (3) @(negedge clk);
    release_bus();
    repeat (3) @(negedge clk);
    chk("R8 no target result", n_tgt - b_tgt, 0);
    access(2, 1, 2);
    chk("R8 next access target", last_tgt, 2);

    // R9: request withdrawn before grant
    b_arb = n_arb;
    @(negedge clk) req_n = 0;
    repeat (3) @(negedge clk);
    req_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 no arbitration", n_arb - b_arb, 0);
    access(3, 1, 1);
    chk("R9 fresh arbitration", last_arb, 3);

    // R12: clear on the same edge as a completing result
    @(negedge clk) req_n = 0;
    repeat (2) @(negedge clk);
    gnt_n = 0;
    repeat (2) @(negedge clk);
    frame_n = 0; irdy_n = 0;
    @(negedge clk) begin trdy_n = 0; clr_max = 1; end
    @(negedge clk) begin release_bus(); clr_max = 0; end
    chk("R12 target result still given", last_tgt, 1);
    chk("R12 all maxima cleared", int'(arb_max) + int'(acq_max) + int'(tgt_max), 0);
    access(2, 3, 1);
    chk("R11 arb_max after clear", int'(arb_max), 2);
    access(1, 1, 1);
    chk("R11 acq_max kept when smaller", int'(acq_max), 3);

    // R10: saturation of a long arbitration wait
    access(70000, 1, 1);
    chk("R10 saturated arbitration", last_arb, 65535);
    chk("R10 saturated maximum", int'(arb_max), 65535);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule